// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block tracks the lock reservation that pairs a load-linked access with a later store-conditional in a private data cache. The cache controller presents each request as it completes: its kind, line address, the requesting processor ID, and whether the line is present in the cache. The monitor then updates a single reservation register, which holds a valid bit, a line address and a processor ID. For a store-conditional it also returns a success flag and an extra-data bit to the requester. Remote invalidations or evictions come in on a separate snoop port and drop a reservation that matches their line.

Locked read-modify-write pairs do not use the reservation. When the read half completes, the monitor sends a one-cycle block pulse for the line toward the controller. When the write half completes, it sends an unblock pulse. A bypass input turns off reservation handling for completions. The monitor then reports success for every completion and leaves the reservation unchanged.

Top module: `llsc_monitor`

## Requirements
- R1: While rst_ni is low and after its release, the reservation is invalid and rsp_valid_o, rsp_success_o, rsp_extra_o, block_o and unblock_o are all 0.
- R2: A completing load-linked (cmp_kind_i = 2) with bypass_i low makes the reservation valid with the request's line and processor ID, seen on resv_*_o one cycle later. It reports success 1 and extra 0.
- R3: A store-conditional (cmp_kind_i = 3) with bypass_i low succeeds only when the reservation is valid, matches its line and matches its processor ID, and no snoop hits that reservation in the same cycle. rsp_extra_o is 1 on success and 0 on failure.
- R4: A store-conditional with bypass_i low clears a reservation on its line whatever its outcome, including one owned by another processor ID.
- R5: The other write-class kinds are store 1, locked-RMW read 4, locked-RMW write 5, RMW read 6 and flush 7. With bypass_i low, one of these clears the reservation only when cmp_present_i is 1 and both the line and the processor ID match. Otherwise the reservation is kept.
- R6: A plain load (cmp_kind_i = 0) never changes the reservation and reports success 1, extra 0.
- R7: A load-linked overwrites any earlier reservation, whatever its line or owner.
- R8: When snoop_valid_i is high and snoop_line_i equals the reserved line, the reservation is cleared at the next edge, unless a load-linked sets a new one in the same cycle. A snoop to another line has no effect.
- R9: One cycle after a completing locked-RMW read, block_o pulses. One cycle after a completing locked-RMW write, unblock_o pulses. In both cases blk_line_o carries the request's line, and bypass_i has no effect on this.
- R10: With bypass_i high, every completion reports success 1, a store-conditional reports extra 1, and the reservation keeps its value (snoops still apply).
- R11: rsp_valid_o is high exactly in the cycle after a cycle with cmp_valid_i high. When rsp_valid_o is low, rsp_success_o and rsp_extra_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bypass_i | input | 1 | Disables reservation handling for completions |
| cmp_valid_i | input | 1 | Completion strobe |
| cmp_kind_i | input | 3 | Request kind (0 load, 1 store, 2 LL, 3 SC, 4 locked-RMW rd, 5 locked-RMW wr, 6 RMW rd, 7 flush) |
| cmp_line_i | input | LINE_W | Line address of the completion |
| cmp_pid_i | input | PID_W | Requesting processor ID |
| cmp_present_i | input | 1 | Line is present in the cache |
| snoop_valid_i | input | 1 | Remote invalidation or eviction strobe |
| snoop_line_i | input | LINE_W | Line address of the snoop |
| rsp_valid_o | output | 1 | Response valid, one cycle after completion |
| rsp_success_o | output | 1 | Completion succeeded |
| rsp_extra_o | output | 1 | Extra data returned to the requester |
| block_o | output | 1 | Block-line pulse for a locked-RMW read |
| unblock_o | output | 1 | Unblock-line pulse for a locked-RMW write |
| blk_line_o | output | LINE_W | Line for block or unblock |
| resv_valid_o | output | 1 | Reservation valid |
| resv_line_o | output | LINE_W | Reserved line |
| resv_pid_o | output | PID_W | Reservation owner |

## Verification
The properties assume that at most one completion arrives per cycle and that cmp_kind_i always holds one of the eight defined codes. They also assume that the snoop port and the completion port may hit the same line in the same cycle, with the load-linked setting taking priority. The stimulus drives one completion or idle cycle per clock and draws lines from a pool of four addresses and processor IDs from four values, so reservation hits, owner mismatches and snoop collisions all recur often. Directed sequences cover the overwrite, clear-on-failure and bypass corners before the random phase.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [2:0] {
    K_LOAD    = 3'd0,
    K_STORE   = 3'd1,
    K_LL      = 3'd2,
    K_SC      = 3'd3,
    K_LRMW_RD = 3'd4,
    K_LRMW_WR = 3'd5,
    K_RMW_RD  = 3'd6,
    K_FLUSH   = 3'd7
  } cmp_kind_e;

  typedef struct packed {
    logic ll;
    logic sc;
    logic wr_other;
    logic lrmw_rd;
    logic lrmw_wr;
  } kind_dec_t;
endpackage

// File: rtl/llsc_kind_decode.sv
module llsc_kind_decode
  import llsc_pkg::*;
(
  input  logic [2:0] kind_i,
  output kind_dec_t  dec_o
);
  cmp_kind_e kind;
  assign kind = cmp_kind_e'(kind_i);

  always_comb begin
    dec_o          = '0;
    dec_o.ll       = (kind == K_LL);
    dec_o.sc       = (kind == K_SC);
    dec_o.lrmw_rd  = (kind == K_LRMW_RD);
    dec_o.lrmw_wr  = (kind == K_LRMW_WR);
    // write-class kinds that only cancel a matching reservation
    dec_o.wr_other = (kind == K_STORE) | (kind == K_RMW_RD) | (kind == K_FLUSH)
                   | (kind == K_LRMW_RD) | (kind == K_LRMW_WR);
  end
endmodule

// File: rtl/llsc_resv_store.sv
module llsc_resv_store
  import llsc_pkg::*;
#(
  parameter int unsigned LINE_W = 26,
  parameter int unsigned PID_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              act_i,
  input  kind_dec_t         dec_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic [PID_W-1:0]  pid_i,
  input  logic              present_i,
  input  logic              snp_valid_i,
  input  logic [LINE_W-1:0] snp_line_i,
  output logic              lock_me_o,
  output logic              valid_o,
  output logic [LINE_W-1:0] line_o,
  output logic [PID_W-1:0]  pid_o
);
  logic              valid_q;
  logic [LINE_W-1:0] line_q;
  logic [PID_W-1:0]  pid_q;
  logic snp_hit, eff_valid, line_hit, set_en, clr_en;

  always_comb begin
    snp_hit   = snp_valid_i & valid_q & (snp_line_i == line_q);
    eff_valid = valid_q & ~snp_hit;
    line_hit  = eff_valid & (line_i == line_q);
    lock_me_o = line_hit & (pid_i == pid_q);
    set_en    = act_i & dec_i.ll;
    // SC drops any reservation on its line; other writes only the own one
    clr_en    = act_i & ((dec_i.sc & line_hit) |
                         (dec_i.wr_other & present_i & lock_me_o));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      line_q  <= '0;
      pid_q   <= '0;
    end else if (set_en) begin
      valid_q <= 1'b1;
      line_q  <= line_i;
      pid_q   <= pid_i;
    end else begin
      valid_q <= eff_valid & ~clr_en;
    end
  end

  assign valid_o = valid_q;
  assign line_o  = line_q;
  assign pid_o   = pid_q;
endmodule

// File: rtl/llsc_resp_reg.sv
module llsc_resp_reg
  import llsc_pkg::*;
#(
  parameter int unsigned LINE_W = 26
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              bypass_i,
  input  kind_dec_t         dec_i,
  input  logic              lock_me_i,
  input  logic [LINE_W-1:0] line_i,
  output logic              rsp_valid_o,
  output logic              rsp_success_o,
  output logic              rsp_extra_o,
  output logic              block_o,
  output logic              unblock_o,
  output logic [LINE_W-1:0] blk_line_o
);
  logic succ_d;
  assign succ_d = ~(dec_i.sc & ~bypass_i & ~lock_me_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o   <= 1'b0;
      rsp_success_o <= 1'b0;
      rsp_extra_o   <= 1'b0;
      block_o       <= 1'b0;
      unblock_o     <= 1'b0;
      blk_line_o    <= '0;
    end else begin
      rsp_valid_o   <= valid_i;
      rsp_success_o <= valid_i & succ_d;
      rsp_extra_o   <= valid_i & dec_i.sc & succ_d;
      block_o       <= valid_i & dec_i.lrmw_rd;
      unblock_o     <= valid_i & dec_i.lrmw_wr;
      if (valid_i & (dec_i.lrmw_rd | dec_i.lrmw_wr)) blk_line_o <= line_i;
    end
  end
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
  import llsc_pkg::*;
#(
  parameter int unsigned LINE_W = 26,
  parameter int unsigned PID_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bypass_i,
  input  logic              cmp_valid_i,
  input  logic [2:0]        cmp_kind_i,
  input  logic [LINE_W-1:0] cmp_line_i,
  input  logic [PID_W-1:0]  cmp_pid_i,
  input  logic              cmp_present_i,
  input  logic              snoop_valid_i,
  input  logic [LINE_W-1:0] snoop_line_i,
  output logic              rsp_valid_o,
  output logic              rsp_success_o,
  output logic              rsp_extra_o,
  output logic              block_o,
  output logic              unblock_o,
  output logic [LINE_W-1:0] blk_line_o,
  output logic              resv_valid_o,
  output logic [LINE_W-1:0] resv_line_o,
  output logic [PID_W-1:0]  resv_pid_o
);
  kind_dec_t dec;
  logic      lock_me;
  logic      act;

  assign act = cmp_valid_i & ~bypass_i;

  llsc_kind_decode i_dec (
    .kind_i (cmp_kind_i),
    .dec_o  (dec)
  );

  llsc_resv_store #(.LINE_W(LINE_W), .PID_W(PID_W)) i_resv (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .act_i       (act),
    .dec_i       (dec),
    .line_i      (cmp_line_i),
    .pid_i       (cmp_pid_i),
    .present_i   (cmp_present_i),
    .snp_valid_i (snoop_valid_i),
    .snp_line_i  (snoop_line_i),
    .lock_me_o   (lock_me),
    .valid_o     (resv_valid_o),
    .line_o      (resv_line_o),
    .pid_o       (resv_pid_o)
  );

  llsc_resp_reg #(.LINE_W(LINE_W)) i_resp (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .valid_i       (cmp_valid_i),
    .bypass_i      (bypass_i),
    .dec_i         (dec),
    .lock_me_i     (lock_me),
    .line_i        (cmp_line_i),
    .rsp_valid_o   (rsp_valid_o),
    .rsp_success_o (rsp_success_o),
    .rsp_extra_o   (rsp_extra_o),
    .block_o       (block_o),
    .unblock_o     (unblock_o),
    .blk_line_o    (blk_line_o)
  );
endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk #(
  parameter int unsigned LINE_W = 26,
  parameter int unsigned PID_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bypass_i,
  input logic              cmp_valid_i,
  input logic [2:0]        cmp_kind_i,
  input logic [LINE_W-1:0] cmp_line_i,
  input logic [PID_W-1:0]  cmp_pid_i,
  input logic              snoop_valid_i,
  input logic [LINE_W-1:0] snoop_line_i,
  input logic              rsp_valid_o,
  input logic              rsp_success_o,
  input logic              rsp_extra_o,
  input logic              block_o,
  input logic              unblock_o,
  input logic              resv_valid_o,
  input logic [LINE_W-1:0] resv_line_o,
  input logic [PID_W-1:0]  resv_pid_o
);
  logic ll_act;
  assign ll_act = cmp_valid_i & ~bypass_i & (cmp_kind_i == 3'd2);

  p_rsp_follows_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_valid_i |=> rsp_valid_o);
  p_rsp_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmp_valid_i |=> (!rsp_valid_o && !rsp_success_o && !rsp_extra_o));
  p_extra_succ_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_extra_o |-> rsp_success_o);
  p_ll_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ll_act |=> (resv_valid_o && resv_line_o == $past(cmp_line_i)
                && resv_pid_o == $past(cmp_pid_i)));
  p_sc_clears_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_valid_i && !bypass_i && cmp_kind_i == 3'd3 && resv_valid_o
     && cmp_line_i == resv_line_o) |=> !resv_valid_o);
  p_load_keeps_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_valid_i && cmp_kind_i == 3'd0 && !snoop_valid_i)
    |=> ($stable(resv_valid_o) && $stable(resv_line_o) && $stable(resv_pid_o)));
  p_snoop_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snoop_valid_i && resv_valid_o && snoop_line_i == resv_line_o && !ll_act)
    |=> !resv_valid_o);
  p_blk_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(block_o && unblock_o));
  p_bypass_succ_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_valid_i && bypass_i) |=> rsp_success_o);
endmodule

bind llsc_monitor llsc_monitor_chk #(.LINE_W(LINE_W), .PID_W(PID_W)) i_llsc_monitor_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .bypass_i      (bypass_i),
  .cmp_valid_i   (cmp_valid_i),
  .cmp_kind_i    (cmp_kind_i),
  .cmp_line_i    (cmp_line_i),
  .cmp_pid_i     (cmp_pid_i),
  .snoop_valid_i (snoop_valid_i),
  .snoop_line_i  (snoop_line_i),
  .rsp_valid_o   (rsp_valid_o),
  .rsp_success_o (rsp_success_o),
  .rsp_extra_o   (rsp_extra_o),
  .block_o       (block_o),
  .unblock_o     (unblock_o),
  .resv_valid_o  (resv_valid_o),
  .resv_line_o   (resv_line_o),
  .resv_pid_o    (resv_pid_o)
);

// File: tb/test_llsc_monitor.sv
module test_llsc_monitor;
  localparam int unsigned LINE_W     = 26;
  localparam int unsigned PID_W      = 4;
  localparam int unsigned CLK_PERIOD = 10;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              bypass_i = 1'b0;
  logic              cmp_valid_i = 1'b0;
  logic [2:0]        cmp_kind_i = '0;
  logic [LINE_W-1:0] cmp_line_i = '0;
  logic [PID_W-1:0]  cmp_pid_i = '0;
  logic              cmp_present_i = 1'b0;
  logic              snoop_valid_i = 1'b0;
  logic [LINE_W-1:0] snoop_line_i = '0;
  logic              rsp_valid_o, rsp_success_o, rsp_extra_o, block_o, unblock_o;
  logic [LINE_W-1:0] blk_line_o, resv_line_o;
  logic              resv_valid_o;
  logic [PID_W-1:0]  resv_pid_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // reference reservation
  logic              m_v = 1'b0;
  logic [LINE_W-1:0] m_line = '0;
  logic [PID_W-1:0]  m_pid = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  llsc_monitor #(.LINE_W(LINE_W), .PID_W(PID_W)) i_llsc_monitor (
    .clk_i(clk), .rst_ni(rst_ni), .bypass_i(bypass_i),
    .cmp_valid_i(cmp_valid_i), .cmp_kind_i(cmp_kind_i), .cmp_line_i(cmp_line_i),
    .cmp_pid_i(cmp_pid_i), .cmp_present_i(cmp_present_i),
    .snoop_valid_i(snoop_valid_i), .snoop_line_i(snoop_line_i),
    .rsp_valid_o(rsp_valid_o), .rsp_success_o(rsp_success_o), .rsp_extra_o(rsp_extra_o),
    .block_o(block_o), .unblock_o(unblock_o), .blk_line_o(blk_line_o),
    .resv_valid_o(resv_valid_o), .resv_line_o(resv_line_o), .resv_pid_o(resv_pid_o)
  );

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [LINE_W-1:0] pool_line(input int idx);
    return LINE_W'(32'h0000_0A40 + idx * 3);
  endfunction

  function automatic string tag_of(input logic [2:0] k, input logic byp, input logic snp);
    if (byp) return "R10";
    if (snp) return "R8";
    case (k)
      3'd0: return "R6";
      3'd2: return "R2";
      3'd3: return "R3";
      3'd4, 3'd5: return "R9";
      default: return "R5";
    endcase
  endfunction

  // one cycle: drive, compute expectation, compare after the edge
  task automatic step(input logic v, input logic [2:0] k, input logic [LINE_W-1:0] ln,
                      input logic [PID_W-1:0] pid, input logic pres, input logic byp,
                      input logic sv, input logic [LINE_W-1:0] sl, input string tag);
    logic snp_hit, eff_v, line_hit, lock_me, e_succ, e_extra;
    logic              n_v;
    logic [LINE_W-1:0] n_line;
    logic [PID_W-1:0]  n_pid;
    @(negedge clk);
    cmp_valid_i = v; cmp_kind_i = k; cmp_line_i = ln; cmp_pid_i = pid;
    cmp_present_i = pres; bypass_i = byp; snoop_valid_i = sv; snoop_line_i = sl;
    snp_hit  = sv & m_v & (sl == m_line);
    eff_v    = m_v & ~snp_hit;
    line_hit = eff_v & (ln == m_line);
    lock_me  = line_hit & (pid == m_pid);
    n_v = eff_v; n_line = m_line; n_pid = m_pid;
    e_succ = 1'b1;
    if (v && !byp) begin
      if (k == 3'd2) begin n_v = 1'b1; n_line = ln; n_pid = pid; end
      else if (k == 3'd3) begin e_succ = lock_me; if (line_hit) n_v = 1'b0; end
      else if (k != 3'd0 && pres && lock_me) n_v = 1'b0;
    end
    e_extra = (k == 3'd3) & e_succ;
    @(posedge clk); #1;
    chk("R11", "rsp_valid", 64'(rsp_valid_o), 64'(v));
    chk(tag, "success", 64'(rsp_success_o), 64'(v & e_succ));
    chk(tag, "extra", 64'(rsp_extra_o), 64'(v & e_extra));
    chk("R9", "block", 64'(block_o), 64'(v & (k == 3'd4)));
    chk("R9", "unblock", 64'(unblock_o), 64'(v & (k == 3'd5)));
    if (v && (k == 3'd4 || k == 3'd5)) chk("R9", "blk_line", 64'(blk_line_o), 64'(ln));
    chk(tag, "resv_valid", 64'(resv_valid_o), 64'(n_v));
    if (n_v) begin
      chk(tag, "resv_line", 64'(resv_line_o), 64'(n_line));
      chk(tag, "resv_pid", 64'(resv_pid_o), 64'(n_pid));
    end
    m_v = n_v; m_line = n_line; m_pid = n_pid;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [LINE_W-1:0] a, b;
    int unsigned seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    a = pool_line(0); b = pool_line(1);
    #(CLK_PERIOD * 2 + 1);
    // R1: during reset
    chk("R1", "resv_valid in reset", 64'(resv_valid_o), 64'd0);
    chk("R1", "rsp_valid in reset", 64'(rsp_valid_o), 64'd0);
    @(negedge clk); rst_ni = 1'b1;
    @(posedge clk); #1;
    chk("R1", "outputs after reset", 64'({rsp_success_o, rsp_extra_o, block_o, unblock_o, resv_valid_o}), 64'd0);

    // directed corners
    step(1, 3'd2, a, 4'd1, 1, 0, 0, '0, "R2");      // LL sets
    step(1, 3'd3, a, 4'd2, 1, 0, 0, '0, "R3");      // wrong pid fails
    step(1, 3'd3, a, 4'd1, 1, 0, 0, '0, "R4");      // cleared by failed SC
    step(1, 3'd2, a, 4'd1, 1, 0, 0, '0, "R2");
    step(1, 3'd2, b, 4'd3, 1, 0, 0, '0, "R7");      // overwrite
    step(1, 3'd3, a, 4'd1, 1, 0, 0, '0, "R7");      // old line gone
    step(1, 3'd2, a, 4'd1, 1, 0, 0, '0, "R2");
    step(1, 3'd0, a, 4'd2, 1, 0, 0, '0, "R6");      // load no effect
    step(1, 3'd1, a, 4'd2, 1, 0, 0, '0, "R5");      // other pid keeps
    step(1, 3'd1, a, 4'd1, 0, 0, 0, '0, "R5");      // not present keeps
    step(1, 3'd3, a, 4'd1, 1, 0, 0, '0, "R3");      // success
    step(1, 3'd2, a, 4'd1, 1, 0, 0, '0, "R2");
    step(1, 3'd7, a, 4'd1, 1, 0, 0, '0, "R5");      // flush clears
    step(1, 3'd2, a, 4'd1, 1, 0, 0, '0, "R2");
    step(0, 3'd0, '0, 4'd0, 0, 0, 1, b, "R8");      // miss snoop
    step(1, 3'd3, a, 4'd1, 1, 0, 1, a, "R8");       // same-cycle snoop fails SC
    step(1, 3'd2, b, 4'd2, 1, 1, 0, '0, "R10");     // bypass LL no set
    step(1, 3'd3, b, 4'd2, 1, 1, 0, '0, "R10");     // bypass SC succeeds
    step(1, 3'd4, b, 4'd2, 1, 1, 0, '0, "R9");      // block under bypass
    step(1, 3'd5, b, 4'd2, 1, 0, 0, '0, "R9");
    step(0, 3'd3, a, 4'd1, 1, 0, 0, '0, "R11");

    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic v, byp, sv, pres;
      logic [2:0] k;
      logic [LINE_W-1:0] ln, sl;
      logic [PID_W-1:0] pid;
      v    = ($urandom % 8) != 0;
      k    = 3'($urandom % 8);
      if (($urandom % 3) == 0) k = 3'd2;
      else if (($urandom % 3) == 0) k = 3'd3;
      ln   = pool_line(int'($urandom % 4));
      pid  = PID_W'($urandom % 4);
      pres = ($urandom % 4) != 0;
      byp  = ($urandom % 10) == 0;
      sv   = ($urandom % 6) == 0;
      sl   = pool_line(int'($urandom % 4));
      step(v, k, ln, pid, pres, byp, sv, sl, tag_of(k, byp, sv));
    end
    finish_run();
  end
endmodule